// File: doc/BRIEF.md
# Power Budget Deviation Monitor

This block measures how closely total chip power tracks a power target. A stream of total-power samples, each marked by a valid strobe, is summed over one-millisecond windows that a millisecond tick closes. At each tick the window sum is divided by the nominal number of samples per millisecond to give the window mean. The absolute distance between that mean and the target is then added to an interval total. After a fixed number of windows the interval total is divided by the window count. The resulting mean deviation is reported together with its size as a percentage of the target.

A per-core sample bus arrives alongside the total. Each core's value is compared with a common per-core ceiling, and a flag for that core is raised in the same cycle. All three divisions (window mean, interval mean, percentage) are done by one sequential shift-subtract divider design that is instantiated three times.

Top module: `pdm_deviation_monitor`

## Requirements
- R1: While `rst_n` is low and in the cycle after it rises, `dev_valid` is 0. After a reset, `dev_value`, `dev_pct` and every accumulator are 0.
- R2: A window's mean is the floor of (sum of the samples accepted since the previous tick, including a sample whose `samp_valid` coincides with `ms_tick`) divided by `SAMPLES_PER_MS`.
- R3: Each window contributes |window mean − `target`|, whichever of the two is larger.
- R4: After every `INTERVAL_MS`-th tick, `dev_value` reports the floor of the sum of that interval's contributions divided by `INTERVAL_MS`.
- R5: `dev_valid` is a pulse exactly one cycle wide, given once per completed interval and at no other time.
- R6: `dev_pct` equals floor(`dev_value` × 100 / `target`). A target of 0 gives all ones in `dev_pct`.
- R7: `core_over[i]` is 1 in the same cycle that `samp_valid` is 1 and core i's field of `core_samp` (bits i×`SAMP_W` upward) is greater than `core_limit`. Otherwise it is 0.
- R8: With `SAMPLES_PER_MS` samples per window, all at the largest sample value, nothing wraps: the window mean equals that largest value.
- R9: Sample data present while `samp_valid` is 0 has no effect on any report.
- R10: The first interval that completes after a reset, including one that cuts short an interval in progress, is reported normally and contains only post-reset samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| samp_valid | input | 1 | Sample strobe for `samp_total` and `core_samp` |
| samp_total | input | SAMP_W | Total chip power sample |
| core_samp | input | NUM_CORES×SAMP_W | Per-core power samples, core i in bits i×SAMP_W upward |
| core_limit | input | SAMP_W | Per-core power ceiling |
| target | input | SAMP_W | Chip power target |
| ms_tick | input | 1 | One-cycle pulse that closes a millisecond window |
| dev_valid | output | 1 | One-cycle report strobe |
| dev_value | output | SAMP_W | Mean absolute deviation over the interval |
| dev_pct | output | SAMP_W+7 | Deviation as a percentage of the target |
| core_over | output | NUM_CORES | Per-core over-ceiling flags |

## Verification
The hardest case to reach is a reset that lands in the middle of an interval while windows are still being summed. The first report after it must contain none of the windows that came before the reset. The bench runs four windows of random data, pulses reset, and then runs a full interval whose expected result is computed from a cleared model. Random intervals place a sample on the tick cycle and drive invalid data in the gap cycles. Directed intervals push the window sum to its maximum with a zero target and give a full-scale target with empty windows.

// File: rtl/pdm_pkg.sv
// Shared constants and helpers for the power deviation monitor.
// Assumes operands fit in 32 bits.
package pdm_pkg;
    localparam int unsigned PDM_PCT_SCALE = 100;
    localparam int unsigned PDM_PCT_BITS  = 7;

    // Distance between two unsigned values.
    function automatic logic [31:0] pdm_absdiff(input logic [31:0] a, input logic [31:0] b);
        return (a >= b) ? (a - b) : (b - a);
    endfunction
endpackage

// File: rtl/pdm_seqdiv.sv
// Restoring shift-subtract divider: one quotient bit per cycle.
// NUM_W cycles after start it gives done for one cycle with the quotient.
// Assumes start is not raised while busy. Divisor 0 gives all-ones quotient.
module pdm_seqdiv #(
    parameter int NUM_W = 16,
    parameter int DEN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [NUM_W-1:0] dividend,
    input  logic [DEN_W-1:0] divisor,
    output logic             busy,
    output logic             done,
    output logic [NUM_W-1:0] quotient
);
    localparam int CNT_W = $clog2(NUM_W + 1);

    logic [NUM_W-1:0] quot_q;
    logic [DEN_W-1:0] rem_q;
    logic [DEN_W-1:0] dvs_q;
    logic [CNT_W-1:0] cnt_q;
    logic [DEN_W:0]   shifted;
    logic [DEN_W:0]   trial;
    logic             fits;

    // Trial subtraction for the next quotient bit.
    always_comb begin
        shifted = {rem_q, quot_q[NUM_W-1]};
        fits    = shifted >= {1'b0, dvs_q};
        trial   = shifted - {1'b0, dvs_q};
    end

    // Iteration state and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quot_q <= '0;
            rem_q  <= '0;
            dvs_q  <= '0;
            cnt_q  <= '0;
            busy   <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                quot_q <= dividend;
                rem_q  <= '0;
                dvs_q  <= divisor;
                cnt_q  <= CNT_W'(NUM_W);
                busy   <= 1'b1;
            end else if (busy) begin
                rem_q  <= fits ? trial[DEN_W-1:0] : shifted[DEN_W-1:0];
                quot_q <= {quot_q[NUM_W-2:0], fits};
                cnt_q  <= cnt_q - 1'b1;
                if (cnt_q == CNT_W'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    assign quotient = quot_q;

    a_r4_no_restart: assert property (@(posedge clk) disable iff (!rst_n) start |-> !busy);
    a_r4_done_follows_busy: assert property (@(posedge clk) disable iff (!rst_n) done |-> $past(busy));
endmodule

// File: rtl/pdm_window_acc.sv
// Sums accepted total-power samples over one millisecond window.
// close_sum includes a sample arriving in the tick cycle. The tick clears the sum.
// Assumes at most SAMPLES_PER_MS samples per window, so the width suffices.
module pdm_window_acc #(
    parameter int SAMP_W = 12,
    parameter int WIN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              samp_valid,
    input  logic [SAMP_W-1:0] samp,
    input  logic              ms_tick,
    output logic [WIN_W-1:0]  close_sum
);
    logic [WIN_W-1:0] acc_q;
    logic [WIN_W-1:0] addend;

    // Gate the sample with its strobe.
    always_comb addend = samp_valid ? WIN_W'(samp) : '0;

    assign close_sum = acc_q + addend;

    // Running window sum, restarted at each tick.
    always_ff @(posedge clk) begin
        if (!rst_n)       acc_q <= '0;
        else if (ms_tick) acc_q <= '0;
        else              acc_q <= close_sum;
    end

    a_r8_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (samp_valid && !ms_tick) |=> (acc_q >= $past(acc_q)));
    a_r9_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!samp_valid && !ms_tick) |=> $stable(acc_q));
endmodule

// File: rtl/pdm_interval_acc.sv
// Adds |window mean - target| for each finished window.
// On the last window of an interval it raises int_start with the full sum and clears itself.
module pdm_interval_acc #(
    parameter int WIN_W       = 16,
    parameter int SAMP_W      = 12,
    parameter int INTERVAL_MS = 10,
    parameter int IVL_W       = 4,
    parameter int DEVSUM_W    = 20
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                avg_valid,
    input  logic [WIN_W-1:0]    avg,
    input  logic [SAMP_W-1:0]   target,
    output logic                int_start,
    output logic [DEVSUM_W-1:0] int_sum
);
    import pdm_pkg::*;

    logic [DEVSUM_W-1:0] dev_acc_q;
    logic [IVL_W-1:0]    win_cnt_q;
    logic [WIN_W-1:0]    diff;
    logic                last_win;

    // Error magnitude and end-of-interval detection.
    always_comb begin
        diff      = WIN_W'(pdm_absdiff(32'(avg), 32'(target)));
        int_sum   = dev_acc_q + DEVSUM_W'(diff);
        last_win  = (win_cnt_q == IVL_W'(INTERVAL_MS - 1));
        int_start = avg_valid && last_win;
    end

    // Interval total and window counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dev_acc_q <= '0;
            win_cnt_q <= '0;
        end else if (avg_valid) begin
            if (last_win) begin
                dev_acc_q <= '0;
                win_cnt_q <= '0;
            end else begin
                dev_acc_q <= int_sum;
                win_cnt_q <= win_cnt_q + 1'b1;
            end
        end
    end

    a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        win_cnt_q < IVL_W'(INTERVAL_MS));
    a_r3_diff_bound: assert property (@(posedge clk) disable iff (!rst_n)
        avg_valid |-> (32'(diff) <= ((32'(avg) > 32'(target)) ? 32'(avg) : 32'(target))));
endmodule

// File: rtl/pdm_core_limit.sv
// Compares each core's sample with a common ceiling, combinationally.
// A flag is raised only in a cycle with a valid sample.
module pdm_core_limit #(
    parameter int NUM_CORES = 4,
    parameter int SAMP_W    = 12
) (
    input  logic                        samp_valid,
    input  logic [NUM_CORES*SAMP_W-1:0] core_samp,
    input  logic [SAMP_W-1:0]           core_limit,
    output logic [NUM_CORES-1:0]        over
);
    for (genvar i = 0; i < NUM_CORES; i++) begin : g_core
        // One comparator per core.
        assign over[i] = samp_valid && (core_samp[i*SAMP_W +: SAMP_W] > core_limit);
    end
endmodule

// File: rtl/pdm_deviation_monitor.sv
// Top: window mean -> absolute error vs target -> interval mean -> percentage.
// Assumes ticks are spaced wider than the window divider latency (WIN_W cycles),
// and at most SAMPLES_PER_MS samples per window.
module pdm_deviation_monitor #(
    parameter int SAMP_W         = 12,
    parameter int SAMPLES_PER_MS = 8,
    parameter int INTERVAL_MS    = 10,
    parameter int NUM_CORES      = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        samp_valid,
    input  logic [SAMP_W-1:0]           samp_total,
    input  logic [NUM_CORES*SAMP_W-1:0] core_samp,
    input  logic [SAMP_W-1:0]           core_limit,
    input  logic [SAMP_W-1:0]           target,
    input  logic                        ms_tick,
    output logic                        dev_valid,
    output logic [SAMP_W-1:0]           dev_value,
    output logic [SAMP_W+7-1:0]         dev_pct,
    output logic [NUM_CORES-1:0]        core_over
);
    import pdm_pkg::*;

    localparam int CNT_W    = $clog2(SAMPLES_PER_MS + 1);
    localparam int WIN_W    = SAMP_W + CNT_W;
    localparam int IVL_W    = $clog2(INTERVAL_MS + 1);
    localparam int DEVSUM_W = WIN_W + IVL_W;
    localparam int PCT_W    = SAMP_W + PDM_PCT_BITS;

    logic [WIN_W-1:0]    close_sum;
    logic                win_busy, win_done;
    logic [WIN_W-1:0]    win_avg;
    logic                int_start;
    logic [DEVSUM_W-1:0] int_sum;
    logic                ivl_busy, ivl_done;
    logic [DEVSUM_W-1:0] ivl_quot;
    logic [PCT_W-1:0]    pct_num;
    logic                pct_busy, pct_done;
    logic [PCT_W-1:0]    pct_quot;
    logic [SAMP_W-1:0]   dev_hold_q;

    pdm_window_acc #(.SAMP_W(SAMP_W), .WIN_W(WIN_W)) u_win (
        .clk(clk), .rst_n(rst_n), .samp_valid(samp_valid), .samp(samp_total),
        .ms_tick(ms_tick), .close_sum(close_sum)
    );

    pdm_seqdiv #(.NUM_W(WIN_W), .DEN_W(CNT_W)) u_div_win (
        .clk(clk), .rst_n(rst_n), .start(ms_tick), .dividend(close_sum),
        .divisor(CNT_W'(SAMPLES_PER_MS)), .busy(win_busy), .done(win_done),
        .quotient(win_avg)
    );

    pdm_interval_acc #(
        .WIN_W(WIN_W), .SAMP_W(SAMP_W), .INTERVAL_MS(INTERVAL_MS),
        .IVL_W(IVL_W), .DEVSUM_W(DEVSUM_W)
    ) u_ivl (
        .clk(clk), .rst_n(rst_n), .avg_valid(win_done), .avg(win_avg),
        .target(target), .int_start(int_start), .int_sum(int_sum)
    );

    pdm_seqdiv #(.NUM_W(DEVSUM_W), .DEN_W(IVL_W)) u_div_ivl (
        .clk(clk), .rst_n(rst_n), .start(int_start), .dividend(int_sum),
        .divisor(IVL_W'(INTERVAL_MS)), .busy(ivl_busy), .done(ivl_done),
        .quotient(ivl_quot)
    );

    // Scale the interval mean by 100 for the percentage divide.
    always_comb pct_num = PCT_W'(ivl_quot[SAMP_W-1:0]) * PCT_W'(PDM_PCT_SCALE);

    pdm_seqdiv #(.NUM_W(PCT_W), .DEN_W(SAMP_W)) u_div_pct (
        .clk(clk), .rst_n(rst_n), .start(ivl_done), .dividend(pct_num),
        .divisor(target), .busy(pct_busy), .done(pct_done), .quotient(pct_quot)
    );

    pdm_core_limit #(.NUM_CORES(NUM_CORES), .SAMP_W(SAMP_W)) u_lim (
        .samp_valid(samp_valid), .core_samp(core_samp), .core_limit(core_limit),
        .over(core_over)
    );

    // Hold the interval mean while the percentage is computed.
    always_ff @(posedge clk) begin
        if (!rst_n)        dev_hold_q <= '0;
        else if (ivl_done) dev_hold_q <= ivl_quot[SAMP_W-1:0];
    end

    // Publish both results with a one-cycle strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dev_valid <= 1'b0;
            dev_value <= '0;
            dev_pct   <= '0;
        end else begin
            dev_valid <= pct_done;
            if (pct_done) begin
                dev_value <= dev_hold_q;
                dev_pct   <= pct_quot;
            end
        end
    end

    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        dev_valid |=> !dev_valid);
    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !dev_valid);
    a_r4_mean_fits: assert property (@(posedge clk) disable iff (!rst_n)
        ivl_done |-> (ivl_quot >> SAMP_W) == '0);
    a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        ms_tick |-> !win_busy);
    a_r7_flag_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (|core_over) |-> samp_valid);
    a_r5_chain_order: assert property (@(posedge clk) disable iff (!rst_n)
        pct_done |-> !ivl_busy);
endmodule

// File: tb/pdm_deviation_monitor_tb.sv
`timescale 1ns/1ps
module pdm_deviation_monitor_tb;
    localparam int SW   = 12;
    localparam int SPM  = 8;
    localparam int IVL  = 10;
    localparam int NC   = 4;
    localparam int MAXV = (1 << SW) - 1;
    localparam int PCTW = SW + 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic samp_valid = 1'b0;
    logic [SW-1:0] samp_total = '0;
    logic [NC*SW-1:0] core_samp = '0;
    logic [SW-1:0] core_limit = 12'd3000;
    logic [SW-1:0] target = '0;
    logic ms_tick = 1'b0;
    logic dev_valid;
    logic [SW-1:0] dev_value;
    logic [PCTW-1:0] dev_pct;
    logic [NC-1:0] core_over;

    int unsigned n_checks = 0, n_fail = 0;
    int unsigned pulse_cnt = 0, pulse_err = 0, exp_pulses = 0;
    int unsigned win_sum = 0, int_acc = 0;
    logic prev_dv = 1'b0;
    bit done_flag = 1'b0;

    always #5 clk = ~clk;

    pdm_deviation_monitor #(.SAMP_W(SW), .SAMPLES_PER_MS(SPM), .INTERVAL_MS(IVL), .NUM_CORES(NC)) u_dut (
        .clk(clk), .rst_n(rst_n), .samp_valid(samp_valid), .samp_total(samp_total),
        .core_samp(core_samp), .core_limit(core_limit), .target(target), .ms_tick(ms_tick),
        .dev_valid(dev_valid), .dev_value(dev_value), .dev_pct(dev_pct), .core_over(core_over)
    );

    task automatic check(input string req, input longint unsigned act, input longint unsigned exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int unsigned mod_absdiff(input int unsigned a, input int unsigned b);
        if (a > b) return a - b;
        return b - a;
    endfunction

    function automatic int unsigned mod_pct(input int unsigned d, input int unsigned t);
        if (t == 0) return (1 << PCTW) - 1;
        return (d * 100) / t;
    endfunction

    // Pulse monitor for R5.
    always @(negedge clk) begin
        if (rst_n) begin
            if (dev_valid) pulse_cnt++;
            if (dev_valid && prev_dv) pulse_err++;
        end
        prev_dv = dev_valid;
    end

    task automatic drive_cores(output logic [NC-1:0] expo, input bit vld);
        for (int c = 0; c < NC; c++) begin
            int unsigned cv = $urandom_range(0, MAXV);
            core_samp[c*SW +: SW] = SW'(cv);
            expo[c] = vld && (cv > 3000);
        end
    endtask

    // mode: 0 random, 1 all full-scale with a tick sample, 2 empty
    task automatic run_window(input int mode);
        int unsigned k, npre, v;
        bit on_tick;
        logic [NC-1:0] expo;
        k = (mode == 1) ? SPM : (mode == 2) ? 0 : $urandom_range(0, SPM);
        on_tick = (mode == 1) ? 1'b1 : (k > 0) ? 1'($urandom_range(0, 1)) : 1'b0;
        npre = on_tick ? k - 1 : k;
        for (int i = 0; i < int'(npre); i++) begin
            @(negedge clk);
            v = (mode == 1) ? MAXV : $urandom_range(0, MAXV);
            samp_valid = 1'b1; samp_total = SW'(v); win_sum += v;
            drive_cores(expo, 1'b1);
            #1 check("R7 flags with valid sample", core_over, expo);
            @(negedge clk);
            samp_valid = 1'b0; samp_total = SW'($urandom_range(0, MAXV));
            drive_cores(expo, 1'b0);
            #1 check("R7 flags without valid", core_over, 0);
        end
        @(negedge clk);
        ms_tick = 1'b1; samp_valid = on_tick;
        v = (mode == 1) ? MAXV : $urandom_range(0, MAXV);
        samp_total = SW'(v);
        if (on_tick) win_sum += v;
        @(negedge clk);
        ms_tick = 1'b0; samp_valid = 1'b0; samp_total = SW'($urandom_range(0, MAXV));
        repeat (24) @(negedge clk);
        int_acc += mod_absdiff(win_sum / SPM, target);
        win_sum = 0;
    endtask

    task automatic wait_report(output bit seen);
        seen = 1'b0;
        for (int i = 0; i < 400 && !seen; i++) begin
            @(negedge clk);
            if (dev_valid) seen = 1'b1;
        end
    endtask

    task automatic run_interval(input int unsigned tgt, input int mode, input string tag);
        int unsigned edev, epct;
        bit seen;
        target = SW'(tgt);
        int_acc = 0;
        for (int w = 0; w < IVL; w++) begin
            run_window(mode);
            if (w == IVL - 2) check({tag, " R5 no early report"}, pulse_cnt, exp_pulses);
        end
        edev = int_acc / IVL;
        epct = mod_pct(edev, tgt);
        wait_report(seen);
        exp_pulses++;
        check({tag, " R5 report seen"}, seen, 1);
        check({tag, " R2 R3 R4 R9 deviation"}, dev_value, edev);
        check({tag, " R6 percent"}, dev_pct, epct);
        @(negedge clk);
        check({tag, " R5 one pulse per interval"}, pulse_cnt, exp_pulses);
        check({tag, " R5 pulse ended"}, dev_valid, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            n_checks++; n_fail++;
            $display("FAIL R5 watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd24681));
        repeat (4) @(negedge clk);
        check("R1 valid in reset", dev_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 valid after reset", dev_valid, 0);
        check("R1 value after reset", dev_value, 0);
        check("R1 pct after reset", dev_pct, 0);
        check("R7 idle flags", core_over, 0);

        run_interval(2000, 0, "R10 first interval");
        run_interval(0, 1, "R8 full scale zero target");
        run_interval(MAXV, 2, "R3 empty windows");
        for (int n = 0; n < 5; n++)
            run_interval($urandom_range(1, MAXV), 0, "random");

        // Mid-interval reset.
        target = SW'(1500);
        int_acc = 0;
        for (int w = 0; w < 4; w++) run_window(0);
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 valid during reset", dev_valid, 0);
        check("R1 value cleared", dev_value, 0);
        check("R1 pct cleared", dev_pct, 0);
        rst_n = 1'b1;
        win_sum = 0;
        run_interval(1500, 0, "R10 after mid reset");

        check("R5 pulse width", pulse_err, 0);
        done_flag = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule